// File: doc/BRIEF.md
# Ternary-Weight Dot Product Engine

This block forms the dot product of a vector of signed 8-bit activations with a vector of one-bit or two-bit weights. It uses no multiplier. Each lane either passes its activation, inverts it bit by bit, or forces it to zero, depending on its weight. The lane terms then go through a tree of 4:2 carry-save compressors. Carries are not resolved anywhere inside the tree. One carry-propagate adder at the root produces the final sum.

An inverted lane also raises one correction bit, which turns the bitwise inversion into a true two's-complement negation. These bits are counted and enter the root as one more carry-save operand, so the result is exact. A narrow option runs the same 8-bit datapath on 4-bit activations. The engine is a fixed three-stage pipeline: lane terms, then tree root, then final add. It accepts one vector per cycle and returns a 16-bit signed result with a one-cycle valid pulse.

Top module: `tern_dot_engine`

## Requirements
- R1: With `wmode`=1 (ternary), lane i reads `wgt_vec[2i]` as its sign bit and `wgt_vec[2i+1]` as its zero bit. Zero bit set: the lane adds 0. Otherwise a sign bit of 1 subtracts the activation and a sign bit of 0 adds it.
- R2: With `wmode`=0 (binary), lane i reads only `wgt_vec[i]`: 1 adds the activation, 0 subtracts it. Bits N to 2N-1 of `wgt_vec` have no effect on the result.
- R3: The result is exact over the full input range. With N=16, all activations at -128 and all weights negative give +2048; all weights positive give -2048.
- R4: With `narrow`=1, each lane uses bits [3:0] of its activation byte as a signed 4-bit value. Bits [7:4] have no effect.
- R5: A strobe on `in_valid` at a rising edge raises `out_valid` for exactly one cycle after the third rising edge, counting the sampling edge. Strobes on consecutive cycles produce results on consecutive cycles, in the same order.
- R6: `out_sum` is the signed result, sign-extended to 16 bits.
- R7: While reset is held (`rst_n`=0), `out_valid` is 0 and `out_sum` is 0.
- R8: `out_sum` holds its last value in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector strobe |
| wmode | input | 1 | 1 = ternary weights, 0 = binary weights |
| narrow | input | 1 | 1 = 4-bit activations in the low nibble of each byte |
| act_vec | input | N*8 | Activations; lane i occupies bits [8i+7:8i] |
| wgt_vec | input | 2*N | Packed weight register |
| out_valid | output | 1 | Result strobe |
| out_sum | output | 16 | Signed dot product |

## Verification
The bench drives the two extreme vectors where every lane holds -128. A tree that is too narrow wraps +2048 into a negative value. A design that drops the negation correction bits ends up 16 away from the expected value. All zero bits set must give exactly 0, which catches a lane that still leaks its correction bit through a zeroed term. Random upper weight bits in binary mode, and random upper nibbles in narrow mode, expose decoding at the wrong bit positions. A back-to-back burst catches pipeline stages that overwrite each other or that shift the valid pulse.

// File: rtl/tdp_pkg.sv
`timescale 1ns/1ps
package tdp_pkg;
    typedef enum logic {
        WMODE_BINARY  = 1'b0,
        WMODE_TERNARY = 1'b1
    } wmode_e;

    typedef struct packed {
        logic neg;
        logic zero;
    } lane_wt_t;
endpackage

// File: rtl/tdp_lane.sv
`timescale 1ns/1ps
module tdp_lane #(
    parameter int AW = 8,
    parameter int WF = 13
) (
    input  logic [AW-1:0]        act,
    input  logic                 narrow,
    input  tdp_pkg::lane_wt_t    wt,
    output logic [WF-1:0]        term,
    output logic                 negc
);
    localparam int HW = AW / 2;

    logic [AW-1:0] a_eff;
    logic [WF-1:0] a_ext;

    always_comb begin
        if (narrow)
            a_eff = {{(AW-HW){act[HW-1]}}, act[HW-1:0]};
        else
            a_eff = act;
        a_ext = {{(WF-AW){a_eff[AW-1]}}, a_eff};
        term  = '0;
        negc  = 1'b0;
        if (!wt.zero) begin
            term = a_ext ^ {WF{wt.neg}};
            negc = wt.neg;
        end
    end
endmodule

// File: rtl/tdp_csa42.sv
`timescale 1ns/1ps
module tdp_csa42 #(
    parameter int W = 13
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] x;
    logic [W-1:0] m;
    logic [W-2:0] maj1;
    logic [W-2:0] maj2;

    always_comb begin
        x    = a ^ b ^ c;
        maj1 = (a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0]);
        m    = {maj1, 1'b0};
        s    = x ^ m ^ d;
        maj2 = (x[W-2:0] & m[W-2:0]) | (x[W-2:0] & d[W-2:0]) | (m[W-2:0] & d[W-2:0]);
        cy   = {maj2, 1'b0};
    end
endmodule

// File: rtl/tdp_tree.sv
`timescale 1ns/1ps
module tdp_tree #(
    parameter int N  = 16,
    parameter int WF = 13
) (
    input  logic [N*WF-1:0] terms,
    output logic [WF-1:0]   root_s,
    output logic [WF-1:0]   root_c
);
    localparam int LVL  = (N < 2) ? 1 : $clog2(N);
    localparam int NP   = 1 << LVL;
    localparam int HALF = NP / 2;

    logic [WF-1:0] ns [1:NP-1];
    logic [WF-1:0] nc [1:NP-1];

    for (genvar k = 1; k < NP; k++) begin : g_node
        if (k >= HALF) begin : g_leaf
            localparam int L0 = 2 * (k - HALF);
            if (L0 < N) begin : g_a
                assign ns[k] = terms[L0*WF +: WF];
            end else begin : g_a0
                assign ns[k] = '0;
            end
            if (L0 + 1 < N) begin : g_b
                assign nc[k] = terms[(L0+1)*WF +: WF];
            end else begin : g_b0
                assign nc[k] = '0;
            end
        end else begin : g_mid
            tdp_csa42 #(.W(WF)) u_cmp (
                .a (ns[2*k]),
                .b (nc[2*k]),
                .c (ns[2*k+1]),
                .d (nc[2*k+1]),
                .s (ns[k]),
                .cy(nc[k])
            );
        end
    end

    assign root_s = ns[1];
    assign root_c = nc[1];
endmodule

// File: rtl/tern_dot_engine.sv
`timescale 1ns/1ps
module tern_dot_engine #(
    parameter int N     = 16,
    parameter int AW    = 8,
    parameter int OUT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              wmode,
    input  logic              narrow,
    input  logic [N*AW-1:0]   act_vec,
    input  logic [2*N-1:0]    wgt_vec,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_sum
);
    import tdp_pkg::*;

    localparam int WF   = AW + $clog2(N) + 1;
    localparam int CW   = $clog2(N + 1);
    localparam int MAXP = N * (2 ** (AW - 1));

    // lane gating
    lane_wt_t        wt    [N];
    logic [N*WF-1:0] terms_c;
    logic [N-1:0]    negc_c;

    for (genvar i = 0; i < N; i++) begin : g_lane
        always_comb begin
            if (wmode == WMODE_TERNARY) begin
                wt[i].neg  = wgt_vec[2*i];
                wt[i].zero = wgt_vec[2*i+1];
            end else begin
                wt[i].neg  = ~wgt_vec[i];
                wt[i].zero = 1'b0;
            end
        end
        tdp_lane #(.AW(AW), .WF(WF)) u_lane (
            .act   (act_vec[i*AW +: AW]),
            .narrow(narrow),
            .wt    (wt[i]),
            .term  (terms_c[i*WF +: WF]),
            .negc  (negc_c[i])
        );
    end

    // stage 1: lane terms
    logic            s1_valid;
    logic [N*WF-1:0] s1_terms;
    logic [N-1:0]    s1_neg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_terms <= '0;
            s1_neg   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_terms <= terms_c;
                s1_neg   <= negc_c;
            end
        end
    end

    // carry-save reduction
    logic [WF-1:0] tree_s, tree_c;
    logic [CW-1:0] negcnt;
    logic [WF-1:0] fin_s, fin_c;

    tdp_tree #(.N(N), .WF(WF)) u_tree (
        .terms (s1_terms),
        .root_s(tree_s),
        .root_c(tree_c)
    );

    always_comb begin
        negcnt = '0;
        for (int i = 0; i < N; i++)
            negcnt = negcnt + CW'(s1_neg[i]);
    end

    tdp_csa42 #(.W(WF)) u_root (
        .a (tree_s),
        .b (tree_c),
        .c (WF'(negcnt)),
        .d ('0),
        .s (fin_s),
        .cy(fin_c)
    );

    // stage 2: root carry-save pair
    logic          s2_valid;
    logic [WF-1:0] s2_s, s2_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_s     <= '0;
            s2_c     <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_s <= fin_s;
                s2_c <= fin_c;
            end
        end
    end

    // stage 3: single carry-propagate add
    logic [WF-1:0] sum_w;
    assign sum_w = s2_s + s2_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid)
                out_sum <= {{(OUT_W-WF){sum_w[WF-1]}}, sum_w};
        end
    end

    // assertions
    AST_VALID_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);                                   // R5
    AST_VALID_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));                             // R5
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> (!out_valid |-> $stable(out_sum)));             // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'($signed(out_sum)) <= MAXP && int'($signed(out_sum)) >= -MAXP)); // R3
endmodule

// File: tb/tern_dot_engine_test.sv
`timescale 1ns/1ps
module tern_dot_engine_test;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          wmode;
    logic          narrow;
    logic [N*8-1:0] act_vec;
    logic [2*N-1:0] wgt_vec;
    logic          out_valid;
    logic [15:0]   out_sum;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tern_dot_engine #(.N(N), .AW(8), .OUT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wmode(wmode),
        .narrow(narrow), .act_vec(act_vec), .wgt_vec(wgt_vec),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    function automatic logic [15:0] model(input logic [N*8-1:0] a, input logic [2*N-1:0] w,
                                          input logic tern, input logic nar);
        int acc = 0;
        for (int i = 0; i < N; i++) begin
            logic [7:0] b = a[i*8 +: 8];
            int v = nar ? int'($signed(b[3:0])) : int'($signed(b));
            if (tern) begin
                if (!w[2*i+1]) acc += w[2*i] ? -v : v;
            end else begin
                acc += w[i] ? v : -v;
            end
        end
        return 16'(acc);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [N*8-1:0] a, input logic [2*N-1:0] w,
                         input logic tern, input logic nar);
        logic [15:0] exp = model(a, w, tern, nar);
        @(negedge clk);
        act_vec = a; wgt_vec = w; wmode = tern; narrow = nar; in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R5 valid pulse", 16'(out_valid), 16'd1);
        check(tag, out_sum, exp);
        @(posedge clk);
        #1;
        check("R5 single-cycle valid", 16'(out_valid), 16'd0);
        check("R8 result held", out_sum, exp);
    endtask

    function automatic logic [N*8-1:0] rand_act();
        logic [N*8-1:0] a;
        for (int i = 0; i < N; i++) a[i*8 +: 8] = 8'($urandom);
        return a;
    endfunction

    initial begin
        logic [N*8-1:0] a, base;
        logic [N*8-1:0] ba [3];
        logic [2*N-1:0] bw [3];
        logic [15:0]    be [3];
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; wmode = 1'b1; narrow = 1'b0;
        act_vec = '0; wgt_vec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset valid", 16'(out_valid), 16'd0);
        check("R7 reset sum", out_sum, 16'd0);
        rst_n = 1'b1;

        // R1 directed ternary: activations 1..16, mixed weights
        for (int i = 0; i < N; i++) a[i*8 +: 8] = 8'(i + 1);
        apply("R1 ternary mixed", a, 32'h1B1B_6C6C, 1'b1, 1'b0);
        apply("R1 ternary all zeroed", rand_act(), 32'hFFFF_FFFF, 1'b1, 1'b0);
        apply("R1 ternary all negative", a, 32'h5555_5555, 1'b1, 1'b0);

        // R2 binary mode, upper weight bits ignored
        apply("R2 binary all plus", a, 32'h0000_FFFF, 1'b0, 1'b0);
        apply("R2 binary upper bits set", a, 32'hA5C3_00F0, 1'b0, 1'b0);
        apply("R2 binary upper bits clear", a, 32'h0000_00F0, 1'b0, 1'b0);

        // R3 / R6 extremes
        a = {N{8'h80}};
        apply("R3 max positive", a, 32'h5555_5555, 1'b1, 1'b0);
        apply("R3 R6 max negative", a, 32'h0000_0000, 1'b1, 1'b0);
        apply("R3 binary extreme", a, 32'h0000_0000, 1'b0, 1'b0);

        // R4 narrow mode: upper nibbles must not matter
        a = {N{8'h08}};
        apply("R4 narrow min nibble", a, 32'h0000_0000, 1'b1, 1'b1);
        base = rand_act();
        apply("R4 narrow random upper", base, 32'h1234_5678, 1'b1, 1'b1);
        for (int i = 0; i < N; i++) base[i*8+4 +: 4] = 4'(~base[i*8+4 +: 4]);
        apply("R4 narrow flipped upper", base, 32'h1234_5678, 1'b1, 1'b1);

        // random mix
        for (int k = 0; k < 40; k++) begin
            logic t = 1'($urandom);
            apply(t ? "R1 random ternary" : "R2 random binary",
                  rand_act(), 32'($urandom), t, 1'($urandom));
        end

        // R5 back-to-back burst
        for (int k = 0; k < 3; k++) begin
            ba[k] = rand_act(); bw[k] = 32'($urandom);
            be[k] = model(ba[k], bw[k], 1'b1, 1'b0);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            act_vec = ba[k]; wgt_vec = bw[k]; wmode = 1'b1; narrow = 1'b0; in_valid = 1'b1;
        end
        @(posedge clk);
        #1;
        check("R5 burst 0 valid", 16'(out_valid), 16'd1);
        check("R5 burst 0", out_sum, be[0]);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R5 burst 1 valid", 16'(out_valid), 16'd1);
        check("R5 burst 1", out_sum, be[1]);
        @(posedge clk);
        #1;
        check("R5 burst 2 valid", 16'(out_valid), 16'd1);
        check("R5 burst 2", out_sum, be[2]);
        @(posedge clk);
        #1;
        check("R5 burst end", 16'(out_valid), 16'd0);
        check("R8 burst hold", out_sum, be[2]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule